// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block builds the status word and the interrupt line of a serial peripheral controller. Its inputs are the fill levels of the transmit and receive FIFOs and the events that the serial shifter reports. It does not hold the FIFOs or the shifter. It compares the FIFO counts against two programmable thresholds and tests them for capacity, which gives live level flags. It also records error events in sticky bits that software clears by writing ones.

Three strobes from the shifter drive the sticky side:
- A word that arrives while the receive FIFO is full is lost, and the loss is recorded.
- In slave mode, the remote master may clock out a word while the transmit FIFO is empty.
- A bus-contention or select-while-disabled condition raises a mode fault.

A per-flag enable mask selects which flags reach the single registered interrupt output. The thresholds and the mask are written through simple write strobes and read back on outputs.

Top module: `spi_flag_unit`

## Requirements
- R1: While `rst` is high and on the cycle after, `status`, `irq` and `irq_en` are all zero. Both `tx_mark` and `rx_mark` read 1.
- R2: Status bit 1 (transmit has room) is 1 exactly when `tx_count < tx_mark`. It is updated one clock after the count or the threshold register changes.
- R3: Status bit 4 (receive data ready) is 1 exactly when `rx_count >= rx_mark`. It is updated one clock after the count or the threshold register changes.
- R4: Status bit 2 is 1 when `tx_count` equals the FIFO depth (128 by default). Status bit 5 is 1 when `rx_count` equals the FIFO depth.
- R5: Status bit 0 (receive overrun) becomes 1 one clock after `rx_push` is high while `rx_count` equals the depth. It stays set afterwards. A push below capacity does not set it.
- R6: Status bit 3 (transmit underflow) becomes 1 one clock after `tx_need` is high with `slave_mode` = 1 and `tx_count` = 0. With `slave_mode` = 0 the strobe has no effect.
- R7: Status bit 6 (mode fault) becomes 1 one clock after `mode_fault` is high, and it stays set.
- R8: A cycle with `clr_wr` high clears each of the sticky bits 0, 3 and 6 whose `clr_mask` bit is 1. Bits written with 0 are kept. Clearing has no effect on the level bits 1, 2, 4 and 5.
- R9: When a sticky bit is set and cleared in the same cycle, it ends up set.
- R10: `irq` is 1 exactly one clock after any bit of `status & irq_en` is 1, and 0 one clock after none is.
- R11: `tx_mark_wr`, `rx_mark_wr` and `irq_en_wr` load their data inputs. The new value appears on `tx_mark`, `rx_mark` and `irq_en` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_count | input | 8 | Transmit FIFO occupancy (0..depth) |
| rx_count | input | 8 | Receive FIFO occupancy (0..depth) |
| rx_push | input | 1 | Shifter delivers a received word |
| tx_need | input | 1 | Shifter requests a word to send |
| slave_mode | input | 1 | 1 when the controller is a slave |
| mode_fault | input | 1 | Mode-fault event strobe |
| tx_mark_wr | input | 1 | Load transmit threshold |
| tx_mark_wdata | input | 8 | New transmit threshold |
| rx_mark_wr | input | 1 | Load receive threshold |
| rx_mark_wdata | input | 8 | New receive threshold |
| irq_en_wr | input | 1 | Load interrupt enable mask |
| irq_en_wdata | input | 7 | New enable mask |
| clr_wr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 7 | Bits to clear |
| status | output | 7 | Flag word, bit positions as in R2 to R7 |
| tx_mark | output | 8 | Current transmit threshold |
| rx_mark | output | 8 | Current receive threshold |
| irq_en | output | 7 | Current enable mask |
| irq | output | 1 | Registered interrupt request |

## Verification
Two situations are the hardest to reach from the ports. One is an event strobe that coincides with a clear write of the same bit. The other is an overrun, which needs a push exactly while the receive count sits at the full depth. The random stimulus biases the counts towards 0, the depth and values next to the thresholds, and it fires clear writes with random masks on a third of the steps. Directed steps pin down the coincident set-and-clear cases, the master-mode underflow case and the clears aimed at level bits.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int NFLAG      = 7;
  localparam int B_RX_OVR   = 0;
  localparam int B_TX_ROOM  = 1;
  localparam int B_TX_FULL  = 2;
  localparam int B_TX_UDF   = 3;
  localparam int B_RX_READY = 4;
  localparam int B_RX_FULL  = 5;
  localparam int B_MFAULT   = 6;
  localparam int NSTICKY    = 3;
endpackage

// File: rtl/spi_mark_regs.sv
module spi_mark_regs #(
  parameter int CW = 8,
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_wr,
  input  logic [CW-1:0] tx_wdata,
  input  logic          rx_wr,
  input  logic [CW-1:0] rx_wdata,
  input  logic          en_wr,
  input  logic [NF-1:0] en_wdata,
  output logic [CW-1:0] tx_mark_q,
  output logic [CW-1:0] rx_mark_q,
  output logic [NF-1:0] en_q
);
  localparam logic [CW-1:0] MARK_INIT = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_mark_q <= MARK_INIT;
      rx_mark_q <= MARK_INIT;
      en_q      <= '0;
    end else begin
      if (tx_wr) tx_mark_q <= tx_wdata;
      if (rx_wr) rx_mark_q <= rx_wdata;
      if (en_wr) en_q      <= en_wdata;
    end
  end

  a_r11_tx_mark_load: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> tx_mark_q == $past(tx_wdata));
  a_r11_en_load: assert property (@(posedge clk) disable iff (rst)
    en_wr |=> en_q == $past(en_wdata));
endmodule

// File: rtl/spi_level_flags.sv
module spi_level_flags #(
  parameter int DEPTH = 128,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_mark,
  input  logic [CW-1:0] rx_mark,
  output logic          tx_room_q,
  output logic          tx_full_q,
  output logic          rx_ready_q,
  output logic          rx_full_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_room_q  <= 1'b0;
      tx_full_q  <= 1'b0;
      rx_ready_q <= 1'b0;
      rx_full_q  <= 1'b0;
    end else begin
      tx_room_q  <= tx_count < tx_mark;
      tx_full_q  <= tx_count == FULL;
      rx_ready_q <= rx_count >= rx_mark;
      rx_full_q  <= rx_count == FULL;
    end
  end

  a_r4_tx_full: assert property (@(posedge clk) disable iff (rst)
    (tx_count == FULL) |=> tx_full_q);
  a_r4_rx_full: assert property (@(posedge clk) disable iff (rst)
    (rx_count == FULL) |=> rx_full_q);
  a_r2_room_clear: assert property (@(posedge clk) disable iff (rst)
    (tx_count >= tx_mark) |=> !tx_room_q);
  a_r3_ready_clear: assert property (@(posedge clk) disable iff (rst)
    (rx_count < rx_mark) |=> !rx_ready_q);
endmodule

// File: rtl/spi_sticky_events.sv
module spi_sticky_events #(
  parameter int NS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set_ev,
  input  logic [NS-1:0] clr_en,
  output logic [NS-1:0] stk_q
);
  for (genvar g = 0; g < NS; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)            stk_q[g] <= 1'b0;
      else if (set_ev[g]) stk_q[g] <= 1'b1;
      else if (clr_en[g]) stk_q[g] <= 1'b0;
    end

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set_ev[g] |=> stk_q[g]);
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (stk_q[g] && !clr_en[g]) |=> stk_q[g]);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_en[g] && !set_ev[g]) |=> !stk_q[g]);
  end
endmodule

// File: rtl/spi_irq_merge.sv
module spi_irq_merge #(
  parameter int NF = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] flags,
  input  logic [NF-1:0] enable,
  output logic          irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flags & enable);
  end

  a_r10_raise: assert property (@(posedge clk) disable iff (rst)
    (|(flags & enable)) |=> irq_q);
  a_r10_drop: assert property (@(posedge clk) disable iff (rst)
    !(|(flags & enable)) |=> !irq_q);
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_flag_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CW-1:0]    tx_count,
  input  logic [CW-1:0]    rx_count,
  input  logic             rx_push,
  input  logic             tx_need,
  input  logic             slave_mode,
  input  logic             mode_fault,
  input  logic             tx_mark_wr,
  input  logic [CW-1:0]    tx_mark_wdata,
  input  logic             rx_mark_wr,
  input  logic [CW-1:0]    rx_mark_wdata,
  input  logic             irq_en_wr,
  input  logic [NFLAG-1:0] irq_en_wdata,
  input  logic             clr_wr,
  input  logic [NFLAG-1:0] clr_mask,
  output logic [NFLAG-1:0] status,
  output logic [CW-1:0]    tx_mark,
  output logic [CW-1:0]    rx_mark,
  output logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic tx_room, tx_full, rx_ready, rx_full;
  logic [NSTICKY-1:0] set_ev, clr_en, stk;

  spi_mark_regs #(.CW(CW), .NF(NFLAG)) u_regs (
    .clk(clk), .rst(rst),
    .tx_wr(tx_mark_wr), .tx_wdata(tx_mark_wdata),
    .rx_wr(rx_mark_wr), .rx_wdata(rx_mark_wdata),
    .en_wr(irq_en_wr), .en_wdata(irq_en_wdata),
    .tx_mark_q(tx_mark), .rx_mark_q(rx_mark), .en_q(irq_en)
  );

  spi_level_flags #(.DEPTH(DEPTH), .CW(CW)) u_level (
    .clk(clk), .rst(rst),
    .tx_count(tx_count), .rx_count(rx_count),
    .tx_mark(tx_mark), .rx_mark(rx_mark),
    .tx_room_q(tx_room), .tx_full_q(tx_full),
    .rx_ready_q(rx_ready), .rx_full_q(rx_full)
  );

  // sticky slot 0 = overrun, 1 = underflow, 2 = mode fault
  always_comb begin
    set_ev[0] = rx_push && (rx_count == FULL);
    set_ev[1] = tx_need && slave_mode && (tx_count == '0);
    set_ev[2] = mode_fault;
    clr_en[0] = clr_wr && clr_mask[B_RX_OVR];
    clr_en[1] = clr_wr && clr_mask[B_TX_UDF];
    clr_en[2] = clr_wr && clr_mask[B_MFAULT];
  end

  spi_sticky_events #(.NS(NSTICKY)) u_sticky (
    .clk(clk), .rst(rst),
    .set_ev(set_ev), .clr_en(clr_en), .stk_q(stk)
  );

  always_comb begin
    status             = '0;
    status[B_RX_OVR]   = stk[0];
    status[B_TX_ROOM]  = tx_room;
    status[B_TX_FULL]  = tx_full;
    status[B_TX_UDF]   = stk[1];
    status[B_RX_READY] = rx_ready;
    status[B_RX_FULL]  = rx_full;
    status[B_MFAULT]   = stk[2];
  end

  spi_irq_merge #(.NF(NFLAG)) u_irq (
    .clk(clk), .rst(rst),
    .flags(status), .enable(irq_en), .irq_q(irq)
  );

  a_r5_overrun: assert property (@(posedge clk) disable iff (rst)
    (rx_push && rx_count == FULL) |=> status[B_RX_OVR]);
  a_r6_master_no_udf: assert property (@(posedge clk) disable iff (rst)
    (!status[B_TX_UDF] && !slave_mode) |=> !status[B_TX_UDF]);
  a_r7_fault: assert property (@(posedge clk) disable iff (rst)
    mode_fault |=> status[B_MFAULT]);
endmodule

// File: tb/spi_flag_unit_test.sv
module spi_flag_unit_test;
  localparam int DEPTH = 128;
  localparam int CW = 8;
  localparam int NF = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] tx_count = '0, rx_count = '0;
  logic rx_push = 0, tx_need = 0, slave_mode = 0, mode_fault = 0;
  logic tx_mark_wr = 0, rx_mark_wr = 0, irq_en_wr = 0, clr_wr = 0;
  logic [CW-1:0] tx_mark_wdata = '0, rx_mark_wdata = '0;
  logic [NF-1:0] irq_en_wdata = '0, clr_mask = '0;
  logic [NF-1:0] status, irq_en;
  logic [CW-1:0] tx_mark, rx_mark;
  logic irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [CW-1:0] m_txm, m_rxm;
  logic [NF-1:0] m_en;
  logic [NF-1:0] m_stk;

  always #5 clk = ~clk;

  spi_flag_unit #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .tx_count(tx_count), .rx_count(rx_count),
    .rx_push(rx_push), .tx_need(tx_need), .slave_mode(slave_mode),
    .mode_fault(mode_fault), .tx_mark_wr(tx_mark_wr), .tx_mark_wdata(tx_mark_wdata),
    .rx_mark_wr(rx_mark_wr), .rx_mark_wdata(rx_mark_wdata),
    .irq_en_wr(irq_en_wr), .irq_en_wdata(irq_en_wdata),
    .clr_wr(clr_wr), .clr_mask(clr_mask), .status(status),
    .tx_mark(tx_mark), .rx_mark(rx_mark), .irq_en(irq_en), .irq(irq)
  );

  function automatic logic [NF-1:0] level_of(input logic [CW-1:0] tc, rc, tm, rm);
    logic [NF-1:0] v = '0;
    v[1] = tc < tm;
    v[2] = tc == CW'(DEPTH);
    v[4] = rc >= rm;
    v[5] = rc == CW'(DEPTH);
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // inputs are already driven; one update edge, then status, then irq
  task automatic step(input string req);
    logic [NF-1:0] setv, clrv, exp_st;
    @(posedge clk); #1;
    setv = '0;
    setv[0] = rx_push && rx_count == CW'(DEPTH);
    setv[3] = tx_need && slave_mode && tx_count == 0;
    setv[6] = mode_fault;
    clrv = clr_wr ? (clr_mask & 7'b1001001) : '0;
    m_stk = (m_stk & ~clrv) | setv;
    if (tx_mark_wr) m_txm = tx_mark_wdata;
    if (rx_mark_wr) m_rxm = rx_mark_wdata;
    if (irq_en_wr) m_en = irq_en_wdata;
    rx_push = 0; tx_need = 0; mode_fault = 0; clr_wr = 0;
    tx_mark_wr = 0; rx_mark_wr = 0; irq_en_wr = 0;
    @(posedge clk); #1;
    exp_st = m_stk | level_of(tx_count, rx_count, m_txm, m_rxm);
    chk({req, " status"}, 32'(status), 32'(exp_st));
    chk("R11 tx_mark", 32'(tx_mark), 32'(m_txm));
    chk("R11 rx_mark", 32'(rx_mark), 32'(m_rxm));
    chk("R11 irq_en", 32'(irq_en), 32'(m_en));
    @(posedge clk); #1;
    chk("R10 irq", 32'(irq), 32'(|(exp_st & m_en)));
  endtask

  function automatic logic [CW-1:0] pick(input logic [CW-1:0] mark);
    case ($urandom % 5)
      0: return '0;
      1: return CW'(DEPTH);
      2: return mark;
      3: return (mark == 0) ? mark : mark - 1;
      default: return CW'($urandom % (DEPTH + 1));
    endcase
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    m_txm = 1; m_rxm = 1; m_en = '0; m_stk = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 status", 32'(status), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 irq_en", 32'(irq_en), 0);
    chk("R1 tx_mark", 32'(tx_mark), 1);
    chk("R1 rx_mark", 32'(rx_mark), 1);
    rst = 0;
    @(posedge clk); #1;
    chk("R1 status after", 32'(status), 32'(level_of(0, 0, 1, 1)));

    // R2/R3 thresholds
    tx_mark_wr = 1; tx_mark_wdata = 8'd10; rx_mark_wr = 1; rx_mark_wdata = 8'd4;
    tx_count = 8'd9; rx_count = 8'd4; step("R2 R3 at marks");
    tx_count = 8'd10; rx_count = 8'd3; step("R2 R3 past marks");
    // R4 full
    tx_count = 8'd128; rx_count = 8'd128; step("R4 both full");
    // R5: push at full sets, below full does not
    irq_en_wr = 1; irq_en_wdata = 7'b1001001;
    rx_count = 8'd127; rx_push = 1; step("R5 push below full");
    rx_count = 8'd128; rx_push = 1; step("R5 overrun");
    // R6: master mode ignored, slave sets
    tx_count = 0; slave_mode = 0; tx_need = 1; step("R6 master ignored");
    slave_mode = 1; tx_need = 1; step("R6 underflow");
    // R7
    mode_fault = 1; step("R7 fault");
    // R8: clear bit 0 only; clearing level bits ignored
    tx_count = 8'd128; clr_wr = 1; clr_mask = 7'b0110111; step("R8 partial clear");
    // R9: set and clear same cycle
    mode_fault = 1; clr_wr = 1; clr_mask = 7'b1111111; step("R9 set wins");
    clr_wr = 1; clr_mask = 7'b1111111; step("R8 clear all");
    irq_en_wr = 1; irq_en_wdata = 0; step("R10 masked");

    // random phase
    for (int i = 0; i < 400; i++) begin
      tx_count = pick(m_txm);
      rx_count = pick(m_rxm);
      slave_mode = $urandom % 2;
      rx_push = ($urandom % 3) == 0;
      tx_need = ($urandom % 3) == 0;
      mode_fault = ($urandom % 8) == 0;
      clr_wr = ($urandom % 3) == 0;
      clr_mask = 7'($urandom);
      if ($urandom % 6 == 0) begin tx_mark_wr = 1; tx_mark_wdata = 8'($urandom % 130); end
      if ($urandom % 6 == 0) begin rx_mark_wr = 1; rx_mark_wdata = 8'($urandom % 130); end
      if ($urandom % 5 == 0) begin irq_en_wr = 1; irq_en_wdata = 7'($urandom); end
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule